// File: doc/BRIEF.md
# Op-Coded Search Memory with Lowest-Address Priority

This block is a small content-addressable store of `ENTRIES` words, each `DATA_W` bits wide, driven by a two-bit operation code. A write operation places a data word at an explicit address. Two search operations take a key and report the lowest address whose stored word equals it. One search leaves the entry in place. The other removes the entry it finds, so that a repeated search for the same key moves on to the next matching address.

Each entry carries a valid flag next to its data. A removed entry stays out of every search until it is written again. Reset fills the store with valid zero words, so a search for zero finds every address from the start. A search result is computed from the contents as they stand before the operation's clock edge. The result is registered at that edge together with a hit flag and a done pulse, and it stays on the outputs until the next search.

Top module: `search_cam`

## Requirements
- R1: An operation code of 2'b01 (write) stores `opData` at address `opAddr` and marks that entry valid; the old word at that address no longer matches.
- R2: An operation code of 2'b10 (keep-search) reports on `resAddr` the lowest address of a valid entry equal to `opData`, with `resHit` high, and changes no entry.
- R3: An operation code of 2'b11 (remove-search) reports the same result as R2 and also invalidates the entry it reports, so a later search no longer finds that address.
- R4: The result of a search on `opCode` at one rising edge appears on `resAddr`/`resHit` after that edge, with `resDone` high for exactly that cycle. After a non-search cycle `resDone` is low and `resAddr`/`resHit` keep their last values.
- R5: When no valid entry matches, a search gives `resHit` low and `resAddr` zero.
- R6: After reset every entry is valid and holds zero, and `resDone`, `resHit` and `resAddr` are zero. A first search for zero therefore hits at address 0.
- R7: When several valid entries match, the lowest index wins, whatever order they were written in.
- R8: An operation code of 2'b00 (idle) changes no entry and no result output.
- R9: Writing to an address whose entry was removed makes that entry valid and searchable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opCode | input | 2 | 00 idle, 01 write, 10 keep-search, 11 remove-search |
| opAddr | input | ADDR_W | Write address (used by write only) |
| opData | input | DATA_W | Write data for a write, search key for a search |
| resAddr | output | ADDR_W | Lowest matching address, zero on a miss |
| resHit | output | 1 | High when the last search found a valid match |
| resDone | output | 1 | High for the cycle after a search operation |

## Verification
A stuck or lost valid flag shows at the ports on the first search for that entry's word. A removed entry would be reported again, or a live one would give a miss or a higher address, in the cycle right after that search. A data bit held wrong shows the same way as soon as its key is searched, so the bench searches every possible key against a store holding distinct words. It also removes repeated words one by one, which exposes the priority order and the deletion in a few cycles. Errors in result timing show in the first cycle: `resDone` is wrong there, or the result outputs move after an idle or write cycle.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_TOP  = 2'b10,
    OP_POP  = 2'b11
  } camOp_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic wrStb;      // write the addressed entry
    logic searchStb;  // register a search result
    logic delStb;     // invalidate the winning entry
  } camStrobe_t;

endpackage

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] opCode,
  output camStrobe_t strobes,
  output logic       resDone
);

  camOp_e opDec;

  always_comb begin
    opDec             = camOp_e'(opCode);
    strobes           = '0;
    unique case (opDec)
      OP_PUSH: strobes.wrStb = 1'b1;
      OP_TOP:  strobes.searchStb = 1'b1;
      OP_POP: begin
        strobes.searchStb = 1'b1;
        strobes.delStb    = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resDone <= 1'b0;
    else        resDone <= strobes.searchStb;
  end

  // R4: a search is followed by a done pulse
  p_done_after_search_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode[1]) |=> resDone);

  // R8: idle and write cycles give no done pulse
  p_no_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!opCode[1]) |=> !resDone);

  // R3: delete only ever rides on a search
  p_del_with_search_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.delStb |-> strobes.searchStb && !strobes.wrStb);

endmodule

// File: rtl/cam_store.sv
module cam_store
  import cam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  camStrobe_t        strobes,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  output logic [ADDR_W-1:0] resAddr,
  output logic              resHit
);

  logic [DATA_W-1:0] dataQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] grantVec;
  logic [ADDR_W-1:0]  winIdx;
  logic               anyMatch;

  // per-entry storage and compare
  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic wrSel;
    logic delSel;

    assign wrSel       = strobes.wrStb && (opAddr == ADDR_W'(i));
    assign delSel      = strobes.delStb && grantVec[i];
    assign matchVec[i] = validQ[i] && (dataQ[i] == opData);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dataQ[i]  <= '0;
        validQ[i] <= 1'b1;
      end else if (wrSel) begin
        dataQ[i]  <= opData;
        validQ[i] <= 1'b1;
      end else if (delSel) begin
        validQ[i] <= 1'b0;
      end
    end
  end

  // lowest-index priority encoder
  always_comb begin
    winIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) winIdx = ADDR_W'(i);
    end
    anyMatch = |matchVec;
    grantVec = anyMatch ? (ENTRIES'(1) << winIdx) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resAddr <= '0;
      resHit  <= 1'b0;
    end else if (strobes.searchStb) begin
      resAddr <= winIdx;
      resHit  <= anyMatch;
    end
  end

  // R7: at most one entry is granted
  p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantVec));

  // R5: a miss reports address zero
  p_miss_addr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !resHit |-> resAddr == '0);

  // R3: the removed entry is invalid afterwards
  p_pop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.delStb && anyMatch) |=> !validQ[$past(winIdx)]);

  // R2: a keep-search leaves every valid flag as it was
  p_top_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.searchStb && !strobes.delStb) |=> validQ == $past(validQ));

  // R1: a written entry is valid afterwards
  p_push_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wrStb |=> validQ[$past(opAddr)]);

endmodule

// File: rtl/search_cam.sv
module search_cam
  import cam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        opCode,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  output logic [ADDR_W-1:0] resAddr,
  output logic              resHit,
  output logic              resDone
);

  camStrobe_t strobes;

  cam_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .opCode  (opCode),
    .strobes (strobes),
    .resDone (resDone)
  );

  cam_store #(
    .ENTRIES (ENTRIES),
    .DATA_W  (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .opAddr  (opAddr),
    .opData  (opData),
    .resAddr (resAddr),
    .resHit  (resHit)
  );

  // R8: result outputs only move after a search
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!opCode[1]) |=> $stable(resAddr) && $stable(resHit));

endmodule

// File: tb/search_cam_tb.sv
module search_cam_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 8;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = $clog2(ENTRIES);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        opCode = 2'b00;
  logic [ADDR_W-1:0] opAddr = '0;
  logic [DATA_W-1:0] opData = '0;
  logic [ADDR_W-1:0] resAddr;
  logic              resHit;
  logic              resDone;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int mVal  [ENTRIES];
  int mData [ENTRIES];
  int lastAddr = 0;
  int lastHit  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  search_cam #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .opCode  (opCode),
    .opAddr  (opAddr),
    .opData  (opData),
    .resAddr (resAddr),
    .resHit  (resHit),
    .resDone (resDone)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic doOp(input logic [1:0] op, input int a, input int d, input string tag);
    int expAddr = 0;
    int expHit  = 0;
    if (op[1]) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (mVal[i] == 1 && mData[i] == d) begin expAddr = i; expHit = 1; end
      if (op == 2'b11 && expHit == 1) mVal[expAddr] = 0;
      lastAddr = expAddr;
      lastHit  = expHit;
    end else if (op == 2'b01) begin
      mVal[a]  = 1;
      mData[a] = d;
    end
    opCode = op;
    opAddr = ADDR_W'(a);
    opData = DATA_W'(d);
    @(posedge clk);
    @(negedge clk);
    opCode = 2'b00;
    chk(resDone == op[1], {tag, " done"}, int'(resDone), int'(op[1]));
    chk(int'(resHit) == lastHit, {tag, " hit"}, int'(resHit), lastHit);
    chk(int'(resAddr) == lastAddr, {tag, " addr"}, int'(resAddr), lastAddr);
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin mVal[i] = 1; mData[i] = 0; end
    repeat (3) @(negedge clk);
    // R6 reset state
    chk(resDone == 1'b0, "R6 reset done", int'(resDone), 0);
    chk(resHit == 1'b0, "R6 reset hit", int'(resHit), 0);
    chk(resAddr == '0, "R6 reset addr", int'(resAddr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: zero found at address 0; R2 keep-search
    doOp(2'b10, 0, 0, "R6 R2 first zero search");
    doOp(2'b10, 0, 0, "R2 repeat keep-search");
    // R3: remove every zero entry, then R5 miss
    for (int i = 0; i <= ENTRIES; i++) doOp(2'b11, 0, 0, "R3 R5 remove sweep");
    // R8: idle leaves results and contents alone
    doOp(2'b00, 0, 0, "R8 idle");
    doOp(2'b10, 0, 0, "R8 R5 search after idle");
    // R1: distinct words everywhere; R4 write gives no done
    for (int i = 0; i < ENTRIES; i++) doOp(2'b01, i, (i * 37 + 5) & 255, "R1 R4 write");
    // R2 R5: every key, twice to show nothing changed
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 256; k++) doOp(2'b10, 0, k, "R2 R5 key sweep");
    // R7: repeated word written out of order
    doOp(2'b01, 6, 170, "R7 write");
    doOp(2'b01, 3, 170, "R7 write");
    doOp(2'b01, 5, 170, "R7 write");
    for (int i = 0; i < 4; i++) doOp(2'b11, 0, 170, "R7 R3 priority remove");
    // R9: rewrite a removed entry
    doOp(2'b01, 5, 170, "R9 rewrite");
    doOp(2'b10, 0, 170, "R9 search rewritten");
    // R1: overwrite drops the old word
    doOp(2'b01, 0, 66, "R1 overwrite");
    doOp(2'b10, 0, 5, "R1 old word gone");
    doOp(2'b10, 0, 66, "R1 new word found");
    // R4: back-to-back searches see the updated contents
    doOp(2'b11, 0, 66, "R4 remove");
    doOp(2'b11, 0, 66, "R4 back-to-back miss");
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule